// File: doc/BRIEF.md
# Line Driver Short-Circuit Retry Controller

This block guards a transmit line driver against a shorted output. A single synchronous fault-sense input covers every short the analog monitor can see: either driver leg tied to the supply rail, either leg tied to ground, or the two legs bridged to each other. When that input is seen high while the driver is running, the block turns the driver off and raises a fault flag.

The driver then stays off for a fixed hold-off window of `HOLD_CYCLES` clocks (default 32). After that it is switched back on for a trial window of `SETTLE_CYCLES` clocks (default 4). If the fault-sense input is high in any cycle of the trial, the driver is turned off again and a new hold-off window starts. The flag stays high the whole time. The flag drops only after a trial window in which the fault never showed, so a short that persists produces one steady flag and no chatter.

Top module: `sc_retry_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `drv_en` is 1 and `fault_flag` is 0.
- R2: With the driver running and the flag clear, a fault-sense high at a clock edge, even for that one cycle only, makes `drv_en` 0 and `fault_flag` 1 right after that edge.
- R3: Once off, the driver stays off for exactly `HOLD_CYCLES` consecutive cycles. Fault-sense activity during this window has no effect on its length.
- R4: At the end of the hold-off window, `drv_en` returns to 1 while `fault_flag` stays 1 for the trial window.
- R5: A fault-sense high at any edge of the trial window, including the last one, turns the driver off again after that edge and starts a new hold-off window of full length. `fault_flag` does not drop.
- R6: A trial window of `SETTLE_CYCLES` cycles with fault-sense low throughout clears `fault_flag` after its last edge. The driver stays on.
- R7: Whenever `drv_en` is 0, `fault_flag` is 1.
- R8: Under a fault that never clears, the driver sequence repeats indefinitely. Each round is `HOLD_CYCLES` cycles off followed by one cycle on, and the flag stays high across every round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fault_sense | input | 1 | Synchronous short-circuit indication from the line monitor |
| drv_en | output | 1 | Line driver enable, 1 = driving |
| fault_flag | output | 1 | Short-circuit alarm |

## Verification
The block is driven with four fault-sense patterns, each aimed at a different part of the behaviour.

- **One-cycle glitch.** Shows that a trip latches a full hold-off window on its own, and that a clean trial clears the flag after exactly the trial length.
- **Constant fault.** Separates a correct retry loop from one that drops the flag between rounds, and fixes the round period at hold-off plus one.
- **Toggling during hold-off.** Shows that the hold-off window neither restarts nor shortens while it runs.
- **Fault on the last trial cycle only.** Tells apart a design that checks the whole trial window from one that decides before the window has ended.

// File: rtl/sc_pkg.sv
package sc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_HOLDOFF = 2'd1,
    ST_RETRY   = 2'd2
  } sc_state_e;

  // True on the last cycle of a window of len cycles counted from zero.
  function automatic bit window_done(int unsigned count, int unsigned len);
    return (count + 1) == len;
  endfunction

  function automatic int unsigned span_of(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sc_sat_counter.sv
module sc_sat_counter #(
  parameter int W    = 6,
  parameter int MAXV = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAXC = W'(MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count <= '0;
    else if (clr)                  count <= '0;
    else if (inc && count != MAXC) count <= count + 1'b1;
  end

  // R3: clearing restarts a window from zero
  a_r3_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);
  // R3: the counter holds at its ceiling instead of wrapping
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && count == MAXC) |=> count == MAXC);

endmodule

// File: rtl/sc_fsm.sv
module sc_fsm
  import sc_pkg::*;
#(
  parameter int HOLD_CYCLES   = 32,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fault_sense,
  output sc_state_e state,
  output logic      ev_trip,
  output logic      ev_hold_done,
  output logic      ev_refault,
  output logic      ev_settle_done
);
  localparam int SPAN  = int'(span_of(HOLD_CYCLES, SETTLE_CYCLES));
  localparam int CNT_W = $clog2(SPAN) + 1;

  logic [CNT_W-1:0] cnt;
  logic             cnt_clr;
  sc_state_e        nxt;

  always_comb begin
    ev_trip        = (state == ST_IDLE) && fault_sense;
    ev_hold_done   = (state == ST_HOLDOFF) && window_done(32'(cnt), HOLD_CYCLES);
    ev_refault     = (state == ST_RETRY) && fault_sense;
    ev_settle_done = (state == ST_RETRY) && !fault_sense &&
                     window_done(32'(cnt), SETTLE_CYCLES);
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:    if (ev_trip)             nxt = ST_HOLDOFF;
      ST_HOLDOFF: if (ev_hold_done)        nxt = ST_RETRY;
      ST_RETRY: begin
        if (ev_refault)                    nxt = ST_HOLDOFF;
        else if (ev_settle_done)           nxt = ST_IDLE;
      end
      default:                             nxt = ST_IDLE;
    endcase
  end

  assign cnt_clr = (nxt != state) || (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  sc_sat_counter #(.W(CNT_W), .MAXV(SPAN)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (1'b1),
    .count (cnt)
  );

  // R2: a sensed fault while running always starts a hold-off
  a_r2_trip: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trip |=> state == ST_HOLDOFF);
  // R3: hold-off is not left before its window completes, whatever the input
  a_r3_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLDOFF && !ev_hold_done) |=> state == ST_HOLDOFF);
  // R4: the end of hold-off opens a fresh trial window
  a_r4_enter_retry: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hold_done |=> (state == ST_RETRY && cnt == '0));
  // R5: a fault seen during the trial goes back to hold-off
  a_r5_refault: assert property (@(posedge clk) disable iff (!rst_n)
    ev_refault |=> (state == ST_HOLDOFF && cnt == '0));
  // R6: a clean trial returns to normal operation
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ev_settle_done |=> state == ST_IDLE);

endmodule

// File: rtl/sc_out_decode.sv
module sc_out_decode
  import sc_pkg::*;
(
  input  sc_state_e state,
  output logic      drv_en,
  output logic      fault_flag
);
  always_comb begin
    drv_en     = (state != ST_HOLDOFF);
    fault_flag = (state != ST_IDLE);
  end
endmodule

// File: rtl/sc_retry_ctrl.sv
module sc_retry_ctrl #(
  parameter int HOLD_CYCLES   = 32,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_sense,
  output logic drv_en,
  output logic fault_flag
);
  sc_pkg::sc_state_e state;
  logic ev_trip, ev_hold_done, ev_refault, ev_settle_done;

  sc_fsm #(.HOLD_CYCLES(HOLD_CYCLES), .SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .fault_sense    (fault_sense),
    .state          (state),
    .ev_trip        (ev_trip),
    .ev_hold_done   (ev_hold_done),
    .ev_refault     (ev_refault),
    .ev_settle_done (ev_settle_done)
  );

  sc_out_decode u_dec (
    .state      (state),
    .drv_en     (drv_en),
    .fault_flag (fault_flag)
  );

  // R1: leaving reset, the driver runs and no alarm is shown
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (drv_en && !fault_flag));
  // R7: the driver is never off without the alarm
  a_r7_off_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> fault_flag);
  // R5, R8: the alarm only falls at the end of a clean trial
  a_r5_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_flag) |-> $past(ev_settle_done));
  // R2: a trip turns the driver off at once
  a_r2_driver_off: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trip |=> !drv_en);

endmodule

// File: tb/tb_sc_retry_ctrl.sv
module tb_sc_retry_ctrl;
  localparam int HOLD   = 32;
  localparam int SETTLE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fault_sense = 1'b0;
  logic drv_en, fault_flag;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  sc_retry_ctrl #(.HOLD_CYCLES(HOLD), .SETTLE_CYCLES(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .fault_sense(fault_sense),
    .drv_en(drv_en), .fault_flag(fault_flag)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Counts negedges with driver off, starting at the current one.
  task automatic count_off(output int n, input bit toggle);
    n = 0;
    while (!drv_en && n < 200) begin
      if (!fault_flag) check(0, "R7 flag low while off", 0, 1);
      n++;
      if (toggle) fault_sense = n[0];
      step();
    end
    if (toggle) fault_sense = 1'b0;
  endtask

  task automatic count_trial(output int n);
    n = 0;
    while (fault_flag && drv_en && n < 200) begin
      n++;
      step();
    end
  endtask

  task automatic t_reset();
    step();
    check(drv_en == 1'b1, "R1 drv_en in reset", int'(drv_en), 1);
    check(fault_flag == 1'b0, "R1 flag in reset", int'(fault_flag), 0);
    rst_n = 1'b1;
    step();
    check(drv_en == 1'b1 && fault_flag == 1'b0, "R1 after release",
          int'({drv_en, fault_flag}), 2);
    step();
    check(drv_en == 1'b1 && fault_flag == 1'b0, "R1 idle steady",
          int'({drv_en, fault_flag}), 2);
  endtask

  task automatic t_glitch();
    int n;
    fault_sense = 1'b1;
    step();
    fault_sense = 1'b0;
    check(drv_en == 1'b0, "R2 glitch driver off", int'(drv_en), 0);
    check(fault_flag == 1'b1, "R2 glitch flag", int'(fault_flag), 1);
    count_off(n, 1'b0);
    check(n == HOLD, "R3 hold-off length", n, HOLD);
    check(drv_en == 1'b1 && fault_flag == 1'b1, "R4 trial state",
          int'({drv_en, fault_flag}), 3);
    count_trial(n);
    check(n == SETTLE, "R6 trial length", n, SETTLE);
    check(fault_flag == 1'b0 && drv_en == 1'b1, "R6 cleared",
          int'({drv_en, fault_flag}), 2);
  endtask

  task automatic t_persistent();
    int n;
    fault_sense = 1'b1;
    step();
    for (int r = 0; r < 3; r++) begin
      count_off(n, 1'b0);
      check(n == HOLD, "R8 round hold-off length", n, HOLD);
      check(drv_en == 1'b1 && fault_flag == 1'b1, "R8 one-cycle retry",
            int'({drv_en, fault_flag}), 3);
      step();
      check(drv_en == 1'b0 && fault_flag == 1'b1, "R5 refault off again",
            int'({drv_en, fault_flag}), 1);
    end
    fault_sense = 1'b0;
    count_off(n, 1'b0);
    check(n == HOLD, "R3 last hold-off length", n, HOLD);
    count_trial(n);
    check(n == SETTLE && !fault_flag, "R6 recovery after persistent", n, SETTLE);
  endtask

  task automatic t_toggle_holdoff();
    int n;
    fault_sense = 1'b1;
    step();
    count_off(n, 1'b1);
    check(n == HOLD, "R3 hold-off ignores toggling", n, HOLD);
    count_trial(n);
    check(n == SETTLE && !fault_flag, "R6 clear after toggling", n, SETTLE);
  endtask

  task automatic t_late_refault();
    int n;
    fault_sense = 1'b1;
    step();
    fault_sense = 1'b0;
    count_off(n, 1'b0);
    for (int i = 0; i < SETTLE - 1; i++) step();
    check(drv_en == 1'b1 && fault_flag == 1'b1, "R4 still in trial",
          int'({drv_en, fault_flag}), 3);
    fault_sense = 1'b1;
    step();
    fault_sense = 1'b0;
    check(drv_en == 1'b0 && fault_flag == 1'b1, "R5 last-cycle refault",
          int'({drv_en, fault_flag}), 1);
    count_off(n, 1'b0);
    check(n == HOLD, "R5 new full hold-off", n, HOLD);
    count_trial(n);
    check(n == SETTLE && !fault_flag, "R6 clear after late refault", n, SETTLE);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_glitch();
    t_persistent();
    t_toggle_holdoff();
    t_late_refault();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule